// File: doc/BRIEF.md
# Static Memory Bus Bridge

This block connects a simple internal request bus to an asynchronous external static memory bus of the NOR flash / PSRAM kind. It accepts one request at a time: byte address, write data, access size and direction, held valid until the block answers with a single-cycle ready pulse. Requests that fall inside a fixed 256 MB window are claimed. Two address bits inside that window pick one of four 64 MB sub-banks, each with its own active-low chip select. The address lines, data lines and strobes are shared by all sub-banks.

The external data width is a parameter, either 8 or 16 bits. The block shifts the external address to match that width. An access wider than the external port is broken into back-to-back external cycles, lowest address first. Each external cycle has a fixed address-setup phase and a fixed data phase, both set by parameters, and is followed by at least one clock with every chip select released. The data bus is split into an output, an output enable and an input, so tristate resolution stays outside the block.

Top module: `static_mem_bridge`

## Requirements
- R1: A request is claimed only when address bits [31:28] equal the window tag (default 4'h6, so 0x6000_0000 to 0x6FFF_FFFF). Any other address gets a one-cycle ready pulse with req_err high and read data zero, and no chip select is asserted.
- R2: Address bits [27:26] = k assert mem_cs_n[k] low, and only that bit, for every external cycle of the access.
- R3: With an 8-bit external width, mem_addr equals the byte address bits [25:0] of the current cycle. Only data lines [7:0] carry data: mem_dq_out[15:8] is zero and mem_dq_in[15:8] is ignored. mem_be_n is 2'b10 while a cycle is active.
- R4: With a 16-bit external width, mem_addr equals the byte address bits [25:1] of the current cycle, with mem_addr[25] zero, and data lines [15:0] are used.
- R5: req_size encodes 0 = byte, 1 = halfword, 2 = word. An access of S bytes on an external port of E bytes is split into max(1, S/E) external cycles. The cycles run in ascending address order. Write data is lane-aligned in the 32-bit word, and each cycle drives the bytes at its own address.
- R6: Read data from each cycle is placed in the byte lanes of rsp_rdata that match the bytes it covers. Lanes the access does not cover read as zero. rsp_rdata is valid while req_ready is high.
- R7: Each external cycle holds the chip select low with both strobes high for ADDSET clocks. It then holds mem_oe_n (read) or mem_we_n (write) low for DATAST clocks. Read data is sampled on the last clock of the data phase. Both strobes are never low together.
- R8: mem_dq_oe is high exactly during the data phase of a write. During reads and idle it is low.
- R9: After each external cycle, all chip selects are high for at least one clock before the next cycle starts.
- R10: req_ready stays low until the last external cycle has finished, then pulses high for exactly one clock. For N cycles this is N*(ADDSET+DATAST+1) clocks after the accepting edge.
- R11: With a 16-bit external width, a byte access drives mem_be_n = 2'b10 for an even address and 2'b01 for an odd address. Halfword and word cycles drive 2'b00. Idle is 2'b11.
- R12: req_size = 3, a halfword at an odd address, or a word not aligned to 4 bytes is answered with an error response as in R1, and no external cycle is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held with its fields until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Lane-aligned write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Error response, valid with req_ready |
| rsp_rdata | output | 32 | Assembled read data, valid with req_ready |
| mem_addr | output | 26 | External address lines |
| mem_dq_out | output | 16 | External data out |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | External data in |
| mem_cs_n | output | 4 | Active-low sub-bank chip selects |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low byte-lane enables |

## Verification
The hardest situation to reach is the boundary between the split cycles of one wide access. At that point the chip select must drop away for one clock, the address and lane offset must step, and partial read data must be held while the next cycle runs. Only word accesses on the 8-bit instance give three such boundaries in a row. So the bench runs a 16-bit and an 8-bit instance side by side, with word, halfword and odd-byte accesses in every sub-bank. It compares every output in every clock against a behavioural timeline built from ADDSET and DATAST. The external memory is modelled as a function of the address, so the lanes assembled on a read are predictable.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_DATA  = 3'd2,
      PH_GAP   = 3'd3,
      PH_RESP  = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_t;

   typedef struct packed {
      logic       err;
      logic [3:0] bank;
      logic [2:0] beats;
   } dec_t;

endpackage

// File: rtl/smb_decode.sv
module smb_decode
   import smb_pkg::*;
#(
   parameter int         EXT_W   = 16,
   parameter logic [3:0] WIN_TAG = 4'h6
) (
   input  logic [3:0] win_bits,
   input  logic [1:0] bank_bits,
   input  logic [1:0] low_bits,
   input  logic [1:0] size,
   output dec_t       dec
);
   localparam int EB = EXT_W / 8;

   logic       miss;
   logic       misalign;
   logic [2:0] nbytes;

   always_comb begin
      miss     = (win_bits != WIN_TAG);
      misalign = 1'b0;
      nbytes   = 3'd1;
      case (acc_size_t'(size))
         SZ_BYTE: nbytes = 3'd1;
         SZ_HALF: begin
            nbytes   = 3'd2;
            misalign = low_bits[0];
         end
         SZ_WORD: begin
            nbytes   = 3'd4;
            misalign = (low_bits != 2'b00);
         end
         default: begin
            nbytes   = 3'd1;
            misalign = 1'b1;
         end
      endcase
      dec.err   = miss | misalign;
      dec.bank  = 4'b0001 << bank_bits;
      dec.beats = (int'(nbytes) > EB) ? 3'(int'(nbytes) / EB) : 3'd1;
   end
endmodule

// File: rtl/smb_seq.sv
module smb_seq
   import smb_pkg::*;
#(
   parameter int ADDSET = 2,
   parameter int DATAST = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       start_err,
   input  logic [2:0] beats,
   output phase_t     phase,
   output logic       data_last,
   output logic       beat_adv,
   output logic       resp_err
);
   localparam int CMAX = (ADDSET > DATAST) ? ADDSET : DATAST;
   localparam int CW   = $clog2(CMAX + 1);

   if (ADDSET < 1) begin : g_bad_addset
      $error("ADDSET must be at least 1");
   end
   if (DATAST < 1) begin : g_bad_datast
      $error("DATAST must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [2:0]    beat;
   logic [2:0]    nbeat;
   logic          err_q;
   logic          last_beat;
   logic          setup_last;

   assign last_beat  = (beat == nbeat - 3'd1);
   assign setup_last = (phase == PH_SETUP) && (cnt == CW'(ADDSET - 1));
   assign data_last  = (phase == PH_DATA) && (cnt == CW'(DATAST - 1));
   assign beat_adv   = data_last && !last_beat;
   assign resp_err   = (phase == PH_RESP) && err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         beat  <= '0;
         nbeat <= 3'd1;
         err_q <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  err_q <= start_err;
                  nbeat <= beats;
                  beat  <= '0;
                  cnt   <= '0;
                  phase <= start_err ? PH_RESP : PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (setup_last) begin
                  cnt   <= '0;
                  phase <= PH_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (data_last) begin
                  cnt <= '0;
                  if (last_beat) begin
                     phase <= PH_RESP;
                  end else begin
                     beat  <= beat + 3'd1;
                     phase <= PH_GAP;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_GAP:  phase <= PH_SETUP;
            PH_RESP: begin
               phase <= PH_IDLE;
               err_q <= 1'b0;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R7: a data phase is only entered from the end of an address-setup phase
   p_setup_before_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA) && ($past(phase) != PH_DATA) |-> $past(setup_last));

   // R10: the response follows either the final data clock or an error decode
   p_resp_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RESP) |-> ($past(data_last) || $past(phase) == PH_IDLE));

   // R12: an error never reaches an external cycle
   p_err_skips_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start && start_err) |=> (phase == PH_RESP));
endmodule

// File: rtl/smb_lanes.sv
module smb_lanes
   import smb_pkg::*;
#(
   parameter int EXT_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [25:0] addr,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   input  logic        write,
   input  logic [3:0]  bank,
   input  phase_t      phase,
   input  logic        data_last,
   input  logic        beat_adv,
   input  logic [15:0] dq_in,
   output logic [25:0] mem_addr,
   output logic [15:0] dq_out,
   output logic [1:0]  be_n,
   output logic [31:0] rdata,
   output logic        write_q,
   output logic [3:0]  bank_q
);
   localparam int       EB     = EXT_W / 8;
   localparam bit [1:0] OFFSTEP = 2'(EB);

   if (EXT_W != 8 && EXT_W != 16) begin : g_bad_width
      $error("EXT_W must be 8 or 16");
   end

   logic [25:2] word_q;
   logic [1:0]  off_q;
   logic [1:0]  size_q;
   logic [31:0] wdata_q;
   logic [31:0] rdata_q;
   logic [1:0]  lane_en;
   logic [1:0]  lane_base;
   logic        active;

   assign active = (phase == PH_SETUP) || (phase == PH_DATA);

   always_comb begin
      if (EXT_W == 8) begin
         lane_en = 2'b01;
      end else if (acc_size_t'(size_q) == SZ_BYTE) begin
         lane_en = off_q[0] ? 2'b10 : 2'b01;
      end else begin
         lane_en = 2'b11;
      end
   end

   if (EXT_W == 8) begin : g_ext8
      assign mem_addr  = {word_q, off_q};
      assign dq_out    = {8'h00, wdata_q[8*off_q +: 8]};
      assign lane_base = off_q;
   end else begin : g_ext16
      assign mem_addr  = {1'b0, word_q, off_q[1]};
      assign dq_out    = wdata_q[16*off_q[1] +: 16];
      assign lane_base = {off_q[1], 1'b0};
   end

   assign be_n  = active ? ~lane_en : 2'b11;
   assign rdata = rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         off_q   <= '0;
         size_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         write_q <= 1'b0;
         bank_q  <= '0;
      end else begin
         if (load) begin
            word_q  <= addr[25:2];
            off_q   <= addr[1:0];
            size_q  <= size;
            wdata_q <= wdata;
            write_q <= write;
            bank_q  <= bank;
            rdata_q <= '0;
         end else begin
            if (data_last && !write_q) begin
               for (int i = 0; i < 2; i++) begin
                  if (lane_en[i]) begin
                     rdata_q[8*(int'(lane_base) + i) +: 8] <= dq_in[8*i +: 8];
                  end
               end
            end
            if (beat_adv) begin
               off_q <= off_q + OFFSTEP;
            end
         end
      end
   end

   // R11: byte enables are released whenever no external cycle is active
   p_be_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (be_n == 2'b11));

   // R5: the lane offset only moves upward inside one access
   p_offset_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(beat_adv) |-> (off_q == $past(off_q) + OFFSTEP));
endmodule

// File: rtl/static_mem_bridge.sv
module static_mem_bridge
   import smb_pkg::*;
#(
   parameter int         EXT_W   = 16,
   parameter int         ADDSET  = 2,
   parameter int         DATAST  = 3,
   parameter logic [3:0] WIN_TAG = 4'h6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [1:0]  req_size,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   output logic        req_ready,
   output logic        req_err,
   output logic [31:0] rsp_rdata,
   output logic [25:0] mem_addr,
   output logic [15:0] mem_dq_out,
   output logic        mem_dq_oe,
   input  logic [15:0] mem_dq_in,
   output logic [3:0]  mem_cs_n,
   output logic        mem_oe_n,
   output logic        mem_we_n,
   output logic [1:0]  mem_be_n
);
   dec_t       dec;
   phase_t     phase;
   logic       start;
   logic       data_last;
   logic       beat_adv;
   logic       resp_err;
   logic       write_q;
   logic [3:0] bank_q;
   logic       in_data;
   logic       active;

   assign start   = req_valid && (phase == PH_IDLE);
   assign in_data = (phase == PH_DATA);
   assign active  = (phase == PH_SETUP) || in_data;

   smb_decode #(.EXT_W(EXT_W), .WIN_TAG(WIN_TAG)) u_decode (
      .win_bits  (req_addr[31:28]),
      .bank_bits (req_addr[27:26]),
      .low_bits  (req_addr[1:0]),
      .size      (req_size),
      .dec       (dec)
   );

   smb_seq #(.ADDSET(ADDSET), .DATAST(DATAST)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_err (dec.err),
      .beats     (dec.beats),
      .phase     (phase),
      .data_last (data_last),
      .beat_adv  (beat_adv),
      .resp_err  (resp_err)
   );

   smb_lanes #(.EXT_W(EXT_W)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .addr      (req_addr[25:0]),
      .size      (req_size),
      .wdata     (req_wdata),
      .write     (req_write),
      .bank      (dec.bank),
      .phase     (phase),
      .data_last (data_last),
      .beat_adv  (beat_adv),
      .dq_in     (mem_dq_in),
      .mem_addr  (mem_addr),
      .dq_out    (mem_dq_out),
      .be_n      (mem_be_n),
      .rdata     (rsp_rdata),
      .write_q   (write_q),
      .bank_q    (bank_q)
   );

   assign mem_cs_n  = active ? ~bank_q : 4'hF;
   assign mem_oe_n  = !(in_data && !write_q);
   assign mem_we_n  = !(in_data && write_q);
   assign mem_dq_oe = in_data && write_q;
   assign req_ready = (phase == PH_RESP);
   assign req_err   = resp_err;

   // R2: at most one sub-bank selected
   p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_cs_n) <= 1);

   // R2: the selected sub-bank does not change while it is held
   p_cs_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n != 4'hF) |=> (mem_cs_n == 4'hF || $stable(mem_cs_n)));

   // R1: an error response follows a clock with no chip select
   p_err_no_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_err) |-> ($past(mem_cs_n) == 4'hF));

   // R7: strobes only inside a selected cycle, never both
   p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != 4'hF && (mem_oe_n || mem_we_n)));

   // R7: a fresh chip select starts with both strobes high
   p_setup_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n == 4'hF) |=> (mem_cs_n == 4'hF || (mem_oe_n && mem_we_n)));

   // R8: data bus driven only under the write strobe
   p_drive_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && mem_oe_n));

   // R9: after a strobe ends, the chip select is released
   p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |=> (!mem_oe_n || !mem_we_n || mem_cs_n == 4'hF));

   // R10: completion is a single-clock pulse
   p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);
endmodule

// File: tb/static_mem_bridge_tb.sv
module static_mem_bridge_tb;
   localparam int AS  = 2;
   localparam int DS  = 3;
   localparam int PER = AS + DS + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v16 = 1'b0, v8 = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  sz = 2'd0;
   logic [31:0] ad = 32'h0;
   logic [31:0] wd = 32'h0;

   logic        rdy16, err16, oe16, oen16, wen16, rdy8, err8, oe8, oen8, wen8;
   logic [31:0] rd16, rd8;
   logic [25:0] a16, a8;
   logic [15:0] do16, do8, di16, di8;
   logic [3:0]  cs16, cs8;
   logic [1:0]  be16, be8;

   int errors = 0;
   int checks = 0;
   bit sel8 = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [7:0] m8(input logic [25:0] a);
      return 8'(int'(a) * 13 + 1);
   endfunction
   function automatic logic [15:0] m16(input logic [25:0] a);
      return {8'(int'(a) * 5 + 3), 8'(int'(a) * 11 + 7)};
   endfunction

   assign di16 = m16(a16);
   assign di8  = {8'hEE, m8(a8)};

   static_mem_bridge #(.EXT_W(16), .ADDSET(AS), .DATAST(DS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(v16), .req_write(wr), .req_size(sz),
      .req_addr(ad), .req_wdata(wd), .req_ready(rdy16), .req_err(err16),
      .rsp_rdata(rd16), .mem_addr(a16), .mem_dq_out(do16), .mem_dq_oe(oe16),
      .mem_dq_in(di16), .mem_cs_n(cs16), .mem_oe_n(oen16), .mem_we_n(wen16),
      .mem_be_n(be16));

   static_mem_bridge #(.EXT_W(8), .ADDSET(AS), .DATAST(DS)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_write(wr), .req_size(sz),
      .req_addr(ad), .req_wdata(wd), .req_ready(rdy8), .req_err(err8),
      .rsp_rdata(rd8), .mem_addr(a8), .mem_dq_out(do8), .mem_dq_oe(oe8),
      .mem_dq_in(di8), .mem_cs_n(cs8), .mem_oe_n(oen8), .mem_we_n(wen8),
      .mem_be_n(be8));

   logic        o_rdy, o_err, o_oe, o_oen, o_wen;
   logic [31:0] o_rd;
   logic [25:0] o_a;
   logic [15:0] o_do;
   logic [3:0]  o_cs;
   logic [1:0]  o_be;

   always_comb begin
      o_rdy = sel8 ? rdy8 : rdy16;
      o_err = sel8 ? err8 : err16;
      o_rd  = sel8 ? rd8  : rd16;
      o_a   = sel8 ? a8   : a16;
      o_do  = sel8 ? do8  : do16;
      o_oe  = sel8 ? oe8  : oe16;
      o_cs  = sel8 ? cs8  : cs16;
      o_oen = sel8 ? oen8 : oen16;
      o_wen = sel8 ? wen8 : wen16;
      o_be  = sel8 ? be8  : be16;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " R2 cs idle"}, 32'(o_cs), 32'hF);
      chk({tag, " R7 strobes idle"}, {30'd0, o_oen, o_wen}, 32'h3);
      chk({tag, " R8 oe idle"}, 32'(o_oe), 32'h0);
      chk({tag, " R11 be idle"}, 32'(o_be), 32'h3);
   endtask

   // one complete access against a behavioural timeline
   task automatic run(input bit w8, input bit w, input logic [31:0] a,
                      input logic [1:0] s, input logic [31:0] d);
      int          eb, n, total, beat, pos, b, base;
      bit          e;
      logic [25:0] ba, ea;
      logic [1:0]  en;
      logic [31:0] exp_rd;
      logic [15:0] lanes;
      eb = w8 ? 1 : 2;
      e  = (a[31:28] != 4'h6) || (s == 2'd3) || (s == 2'd1 && a[0]) ||
           (s == 2'd2 && a[1:0] != 2'b00);
      n  = ((1 << s) > eb) ? (1 << s) / eb : 1;
      total  = e ? 1 : n * PER;
      exp_rd = 32'h0;
      @(negedge clk);
      sel8 = w8; wr = w; ad = a; sz = s; wd = d;
      v8 = w8; v16 = !w8;
      @(posedge clk);
      for (int c = 1; c <= total; c++) begin
         @(negedge clk);
         if (c == total) begin
            chk("R10 ready at completion", 32'(o_rdy), 32'h1);
            chk(e ? "R1/R12 error flag" : "R1 no error", 32'(o_err), 32'(e));
            if (!w || e) chk("R6 read data", o_rd, exp_rd);
            chk_idle("R9 resp");
         end else begin
            chk("R10 ready held off", 32'(o_rdy), 32'h0);
            beat = (c - 1) / PER;
            pos  = (c - 1) % PER;
            b    = int'(a[1:0]) + beat * eb;
            ba   = {a[25:2], 2'b00} + 26'(b);
            ea   = w8 ? ba : {1'b0, ba[25:1]};
            en   = w8 ? 2'b01 : ((s == 2'd0) ? (ba[0] ? 2'b10 : 2'b01) : 2'b11);
            base = w8 ? b : (b & 2);
            if (pos < AS + DS) begin
               chk("R2 bank select", 32'(o_cs), 32'(~(4'b0001 << a[27:26]) & 4'hF));
               chk(w8 ? "R3 address" : "R4 address", 32'(o_a), 32'(ea));
               chk(w8 ? "R3 byte enables" : "R11 byte enables", 32'(o_be), 32'(~en & 2'b11));
               if (pos < AS) begin
                  chk("R7 setup strobes high", {30'd0, o_oen, o_wen}, 32'h3);
                  chk("R8 no drive in setup", 32'(o_oe), 32'h0);
               end else begin
                  chk("R7 data strobe", {30'd0, o_oen, o_wen}, w ? 32'h2 : 32'h1);
                  chk("R8 drive only on write", 32'(o_oe), 32'(w));
                  if (w) begin
                     for (int i = 0; i < 2; i++)
                        if (en[i]) chk("R5 write lane", 32'(o_do[8*i +: 8]),
                                       32'(d[8*(base + i) +: 8]));
                     if (w8) chk("R3 upper lines zero", 32'(o_do[15:8]), 32'h0);
                  end else if (pos == AS + DS - 1) begin
                     lanes = w8 ? {8'h00, m8(ea)} : m16(ea);
                     for (int i = 0; i < 2; i++)
                        if (en[i]) exp_rd[8*(base + i) +: 8] = lanes[8*i +: 8];
                  end
               end
            end else begin
               chk_idle("R9 gap");
            end
         end
      end
      @(posedge clk);
      @(negedge clk);
      v8 = 1'b0; v16 = 1'b0;
      chk("R10 ready single pulse", 32'(o_rdy), 32'h0);
      chk_idle("R9 after access");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      sel8 = 1'b0; chk_idle("reset16");
      chk("R10 reset ready", 32'(o_rdy), 32'h0);
      sel8 = 1'b1; chk_idle("reset8");
      // 16-bit port
      run(1'b0, 1'b1, 32'h6000_0100, 2'd2, 32'hA1B2_C3D4);  // R5 split write
      run(1'b0, 1'b0, 32'h6400_0204, 2'd2, 32'h0);          // R6 split read
      run(1'b0, 1'b1, 32'h6800_0002, 2'd1, 32'h5566_7788);  // R4 upper half
      run(1'b0, 1'b1, 32'h6C00_0003, 2'd0, 32'h9900_0000);  // R11 odd byte
      run(1'b0, 1'b0, 32'h6C00_0010, 2'd0, 32'h0);          // R11 even byte read
      run(1'b0, 1'b0, 32'h6800_0033, 2'd0, 32'h0);          // R6 odd byte read
      run(1'b0, 1'b0, 32'h67FF_FFFE, 2'd1, 32'h0);          // R2 top of bank 1
      run(1'b0, 1'b0, 32'h7000_0000, 2'd2, 32'h0);          // R1 above window
      run(1'b0, 1'b1, 32'h5FFF_FFFC, 2'd2, 32'h1234_5678);  // R1 below window
      run(1'b0, 1'b0, 32'h6000_0000, 2'd3, 32'h0);          // R12 bad size
      run(1'b0, 1'b1, 32'h6000_0001, 2'd1, 32'h0);          // R12 misaligned half
      // 8-bit port
      run(1'b1, 1'b1, 32'h6400_0040, 2'd2, 32'hDEAD_BEEF);  // R3 four cycles
      run(1'b1, 1'b0, 32'h6FFF_FFFC, 2'd2, 32'h0);          // R3/R6 read, bank 3
      run(1'b1, 1'b0, 32'h6800_0007, 2'd0, 32'h0);          // R3 byte read
      run(1'b1, 1'b1, 32'h6000_0012, 2'd1, 32'hCAFE_F00D);  // R5 half in two
      run(1'b1, 1'b1, 32'h6000_0006, 2'd2, 32'h0);          // R12 misaligned word
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule